// File: doc/BRIEF.md
# Floppy controller host register interface

This block is the processor-facing register file of a floppy disk controller. A host drives a two-bit address, an active-low chip select and active-low read and write strobes. Those select four byte-wide registers: status (read) and command (write), track, sector and data. The block keeps the data-request flag and the lost-data flag in step with a simple byte handshake to the disk datapath. In the read direction the datapath presents assembled bytes. In the write direction it asks for the next byte.

A command sequencer outside this block runs the accepted commands. The block hands it each accepted command byte with a one-cycle start pulse, holds the busy state, and takes back a one-cycle done pulse. Force-interrupt commands are decoded here. They end any running command, arm any of three drive conditions (ready rising, ready falling, index pulse), which are ORed, and can latch an immediate interrupt. Only the all-zero force command releases that latch. The drive ready and index inputs are asynchronous and are synchronised inside the block.

Top module: `fdc_host_regs`

## Requirements
- R1: A host write with address 1, 2 or 3 loads the track, sector or data register. A host read with that address returns the register on `rdata`. The track and sector values also appear on `track_out` and `sector_out`.
- R2: With `seq_rd_dir` high, a `dsk_in_vld` pulse loads `dsk_in_byte` into the data register and sets `drq` from the next cycle on. A host read of address 3 clears `drq`, unless a new byte arrives in the same cycle.
- R3: With `seq_rd_dir` high, a byte that arrives while `drq` is still set replaces the unread byte and sets the lost-data flag.
- R4: With `seq_rd_dir` low, a `dsk_req` pulse sets `drq`, and a host write of address 3 clears it. While `drq` is clear, `dsk_out_byte` equals the data register.
- R5: With `seq_rd_dir` low, while `drq` is set `dsk_out_byte` is 0x00. A `dsk_req` in that state sets the lost-data flag.
- R6: A `seq_done` pulse while busy ends busy and raises `intrq` in the next cycle. A status read or an accepted command write clears `intrq`.
- R7: A command write (address 0) whose upper nibble is not 0xD is ignored while busy: no `cmd_start` and no change to `cmd_code`. When idle, the write pulses `cmd_start` for one cycle, shows the byte on `cmd_code`, sets busy and clears `drq`, lost-data and `intrq`.
- R8: A command byte with upper nibble 0xD (force interrupt) is accepted at any time and clears busy. It pulses `cmd_abort` if a command was running. Low nibble 0 raises no interrupt.
- R9: Force-interrupt bit 0 arms ready rising, bit 1 ready falling and bit 2 index rising. Any armed edge raises `intrq`, SYNC_STAGES+1 cycles after the input changes. An accepted command disarms all three.
- R10: Force-interrupt bit 3 raises `intrq` in the next cycle. The interrupt then stays high through status reads and command writes until a 0xD0 command is loaded.
- R11: A force interrupt while busy leaves the status form and the lost-data flag unchanged. While idle it clears `drq` and lost-data and selects the positioning form.
- R12: The status byte has bit 7 = not ready (synchronised) and bit 0 = busy, with bits 6..3 zero. In the positioning form, bit 2 is `seq_trk0` and bit 1 is the synchronised index level. In the transfer form, bit 2 is lost-data and bit 1 is `drq`. Reset selects the positioning form. An accepted command selects the transfer form when its bit 7 is 1, and the positioning form otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low, one cycle |
| wr_n | input | 1 | Host write strobe, active low, one cycle |
| addr | input | 2 | Register select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Register selected by `addr` |
| drq | output | 1 | Data request |
| intrq | output | 1 | Interrupt request |
| drv_ready | input | 1 | Drive ready, asynchronous |
| drv_index | input | 1 | Index pulse, asynchronous |
| seq_trk0 | input | 1 | Head at track zero, from the sequencer |
| seq_rd_dir | input | 1 | 1 = disk-to-host transfer, 0 = host-to-disk |
| seq_done | input | 1 | Command completion pulse |
| cmd_start | output | 1 | One-cycle pulse for an accepted command |
| cmd_code | output | 8 | Last accepted command byte |
| cmd_abort | output | 1 | One-cycle pulse when a force interrupt ends a running command |
| track_out | output | 8 | Track register |
| sector_out | output | 8 | Sector register |
| dsk_in_vld | input | 1 | Assembled byte valid from the disk datapath |
| dsk_in_byte | input | 8 | Assembled byte |
| dsk_req | input | 1 | Disk datapath takes the next byte this cycle |
| dsk_out_byte | output | 8 | Byte offered to the disk datapath |

## Verification
A wrong busy bit shows up on the next command write. `cmd_start` either fires when it should stay low or stays low when it should fire, and status bit 0 reads wrong in the same cycle. A corrupted data-request or lost-data flag shows one cycle after the disk event on `drq`, on `dsk_out_byte` or on status bit 2. A stuck immediate latch or a wrongly armed condition shows on `intrq` within SYNC_STAGES+1 cycles of the edge that should, or should not, raise it. The reference model is compared against every output on every cycle, so each such fault is caught in the first cycle it reaches a port.

// File: rtl/fdc_host_pkg.sv
package fdc_host_pkg;

   localparam int FDC_DW = 8;

   localparam logic [3:0] FORCE_OPC = 4'hD;

   typedef enum logic [1:0] {
      REG_CMDSTAT = 2'd0,
      REG_TRACK   = 2'd1,
      REG_SECTOR  = 2'd2,
      REG_DATA    = 2'd3
   } fdc_reg_e;

   // field order matches the force-interrupt enable bits 2..0
   typedef struct packed {
      logic idx_rise;
      logic rdy_fall;
      logic rdy_rise;
   } fdc_evt_t;

endpackage

// File: rtl/fdc_sync_edge.sv
module fdc_sync_edge #(
   parameter int N      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw,
   output logic [N-1:0] lvl,
   output logic [N-1:0] prv
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fdc_sync_edge: STAGES must be at least 2");
      end
      if (N < 1) begin : g_bad_width
         $error("fdc_sync_edge: N must be at least 1");
      end
   endgenerate

   for (genvar gi = 0; gi < N; gi++) begin : g_chan
      logic [STAGES-1:0] chain;
      logic              last;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
         end else begin
            chain <= {chain[STAGES-2:0], raw[gi]};
            last  <= chain[STAGES-1];
         end
      end

      assign lvl[gi] = chain[STAGES-1];
      assign prv[gi] = last;
   end

endmodule

// File: rtl/fdc_data_reg.sv
module fdc_data_reg #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_dir,
   input  logic          in_vld,
   input  logic [DW-1:0] in_byte,
   input  logic          need,
   input  logic          host_rd,
   input  logic          host_wr,
   input  logic [DW-1:0] host_wdata,
   input  logic          clr,
   output logic [DW-1:0] dr,
   output logic          drq,
   output logic          lost,
   output logic [DW-1:0] out_byte
);

   generate
      if (DW < 1) begin : g_bad_dw
         $error("fdc_data_reg: DW must be positive");
      end
   endgenerate

   logic [DW-1:0] dr_q, dr_next;
   logic          drq_q, drq_next;
   logic          lost_q, lost_evt;

   always_comb begin
      dr_next  = dr_q;
      drq_next = drq_q;
      lost_evt = 1'b0;
      if (rd_dir) begin
         // disk-to-host: an arriving byte wins over a host access
         if (in_vld) begin
            dr_next  = in_byte;
            drq_next = 1'b1;
            lost_evt = drq_q & ~host_rd;
         end else begin
            if (host_wr) dr_next = host_wdata;
            if (host_rd || host_wr) drq_next = 1'b0;
         end
      end else begin
         // host-to-disk: the disk takes the pre-edge content
         if (host_wr) begin
            dr_next  = host_wdata;
            drq_next = 1'b0;
         end else if (need) begin
            drq_next = 1'b1;
         end else if (host_rd) begin
            drq_next = 1'b0;
         end
         lost_evt = need & drq_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dr_q   <= '0;
         drq_q  <= 1'b0;
         lost_q <= 1'b0;
      end else begin
         dr_q <= dr_next;
         if (clr) begin
            drq_q  <= 1'b0;
            lost_q <= 1'b0;
         end else begin
            drq_q  <= drq_next;
            lost_q <= lost_q | lost_evt;
         end
      end
   end

   assign dr       = dr_q;
   assign drq      = drq_q;
   assign lost     = lost_q;
   assign out_byte = drq_q ? '0 : dr_q;

endmodule

// File: rtl/fdc_force_irq.sv
module fdc_force_irq
   import fdc_host_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       force_wr,
   input  logic [3:0] force_bits,
   input  logic       cmd_acc,
   input  fdc_evt_t   evt,
   input  logic       done_evt,
   input  logic       clr_req,
   output logic       intrq,
   output logic       imm_held
);

   localparam int NCOND = $bits(fdc_evt_t);

   logic [NCOND-1:0] cond_q;
   logic             imm_q;
   logic             irq_q;
   logic             cond_hit;
   logic             irq_set;

   assign cond_hit = |(cond_q & NCOND'(evt));
   assign irq_set  = done_evt | (force_wr & force_bits[3]) | cond_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_q <= '0;
         imm_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (force_wr)      cond_q <= force_bits[NCOND-1:0];
         else if (cmd_acc)  cond_q <= '0;

         if (force_wr) begin
            if (force_bits[3])          imm_q <= 1'b1;
            else if (force_bits == 4'h0) imm_q <= 1'b0;
         end

         if (irq_set)      irq_q <= 1'b1;
         else if (clr_req) irq_q <= 1'b0;
      end
   end

   assign intrq    = irq_q | imm_q;
   assign imm_held = imm_q;

endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
   import fdc_host_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [1:0]        addr,
   input  logic [FDC_DW-1:0] wdata,
   output logic [FDC_DW-1:0] rdata,
   output logic              drq,
   output logic              intrq,
   input  logic              drv_ready,
   input  logic              drv_index,
   input  logic              seq_trk0,
   input  logic              seq_rd_dir,
   input  logic              seq_done,
   output logic              cmd_start,
   output logic [FDC_DW-1:0] cmd_code,
   output logic              cmd_abort,
   output logic [FDC_DW-1:0] track_out,
   output logic [FDC_DW-1:0] sector_out,
   input  logic              dsk_in_vld,
   input  logic [FDC_DW-1:0] dsk_in_byte,
   input  logic              dsk_req,
   output logic [FDC_DW-1:0] dsk_out_byte
);

   localparam int NSYNC = 2;
   localparam int SI_RDY = 0;
   localparam int SI_IDX = 1;

   generate
      if (FDC_DW != 8) begin : g_bad_dw
         $error("fdc_host_regs: command decode assumes byte-wide registers");
      end
   endgenerate

   // host access decode
   fdc_reg_e reg_sel;
   logic     host_rd, host_wr;
   logic     wr_cmd, is_force, force_wr, acc_cmd, rd_stat, rd_dr, wr_dr;
   logic     done_evt, clr_req, data_clr;

   assign reg_sel  = fdc_reg_e'(addr);
   assign host_rd  = ~cs_n & ~rd_n;
   assign host_wr  = ~cs_n & ~wr_n;
   assign wr_cmd   = host_wr & (reg_sel == REG_CMDSTAT);
   assign is_force = (wdata[7:4] == FORCE_OPC);
   assign force_wr = wr_cmd & is_force;
   assign rd_stat  = host_rd & (reg_sel == REG_CMDSTAT);
   assign rd_dr    = host_rd & (reg_sel == REG_DATA);
   assign wr_dr    = host_wr & (reg_sel == REG_DATA);

   logic busy_q, type1_q, start_q, abort_q;
   logic [FDC_DW-1:0] cmd_q, trk_q, sec_q;

   assign acc_cmd  = wr_cmd & ~is_force & ~busy_q;
   assign done_evt = seq_done & busy_q & ~force_wr;
   assign clr_req  = rd_stat | acc_cmd | force_wr;
   assign data_clr = acc_cmd | (force_wr & ~busy_q);

   // drive inputs
   logic [NSYNC-1:0] raw_in, s_lvl, s_prv;
   fdc_evt_t         evt;

   assign raw_in[SI_RDY] = drv_ready;
   assign raw_in[SI_IDX] = drv_index;

   fdc_sync_edge #(
      .N      (NSYNC),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_in),
      .lvl   (s_lvl),
      .prv   (s_prv)
   );

   assign evt.rdy_rise = s_lvl[SI_RDY] & ~s_prv[SI_RDY];
   assign evt.rdy_fall = ~s_lvl[SI_RDY] & s_prv[SI_RDY];
   assign evt.idx_rise = s_lvl[SI_IDX] & ~s_prv[SI_IDX];

   // control state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         type1_q <= 1'b1;
         start_q <= 1'b0;
         abort_q <= 1'b0;
         cmd_q   <= '0;
         trk_q   <= '0;
         sec_q   <= '0;
      end else begin
         start_q <= acc_cmd;
         abort_q <= force_wr & busy_q;

         if (force_wr)      busy_q <= 1'b0;
         else if (acc_cmd)  busy_q <= 1'b1;
         else if (done_evt) busy_q <= 1'b0;

         if (force_wr && !busy_q) type1_q <= 1'b1;
         else if (acc_cmd)        type1_q <= ~wdata[7];

         if (acc_cmd) cmd_q <= wdata;
         if (host_wr && reg_sel == REG_TRACK)  trk_q <= wdata;
         if (host_wr && reg_sel == REG_SECTOR) sec_q <= wdata;
      end
   end

   // data register and request flow
   logic [FDC_DW-1:0] dr_val;
   logic              lost_flag;

   fdc_data_reg #(
      .DW (FDC_DW)
   ) u_data (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_dir     (seq_rd_dir),
      .in_vld     (dsk_in_vld),
      .in_byte    (dsk_in_byte),
      .need       (dsk_req),
      .host_rd    (rd_dr),
      .host_wr    (wr_dr),
      .host_wdata (wdata),
      .clr        (data_clr),
      .dr         (dr_val),
      .drq        (drq),
      .lost       (lost_flag),
      .out_byte   (dsk_out_byte)
   );

   // interrupt logic
   logic imm_held;

   fdc_force_irq u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .force_wr   (force_wr),
      .force_bits (wdata[3:0]),
      .cmd_acc    (acc_cmd),
      .evt        (evt),
      .done_evt   (done_evt),
      .clr_req    (clr_req),
      .intrq      (intrq),
      .imm_held   (imm_held)
   );

   // status and read mux
   logic [FDC_DW-1:0] status;

   always_comb begin
      status    = '0;
      status[7] = ~s_lvl[SI_RDY];
      status[0] = busy_q;
      if (type1_q) begin
         status[2] = seq_trk0;
         status[1] = s_lvl[SI_IDX];
      end else begin
         status[2] = lost_flag;
         status[1] = drq;
      end
   end

   always_comb begin
      case (reg_sel)
         REG_CMDSTAT: rdata = status;
         REG_TRACK:   rdata = trk_q;
         REG_SECTOR:  rdata = sec_q;
         default:     rdata = dr_val;
      endcase
   end

   assign cmd_start  = start_q;
   assign cmd_abort  = abort_q;
   assign cmd_code   = cmd_q;
   assign track_out  = trk_q;
   assign sector_out = sec_q;

endmodule

// File: rtl/fdc_host_regs_chk.sv
module fdc_host_regs_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_cmd,
   input logic [7:0] wdata,
   input logic       busy_q,
   input logic       seq_done,
   input logic       intrq,
   input logic       cmd_start,
   input logic       seq_rd_dir,
   input logic       dsk_in_vld,
   input logic       dsk_req,
   input logic       drq,
   input logic       lost_flag,
   input logic       rd_dr,
   input logic       wr_dr,
   input logic       imm_held
);

   AST_BUSY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && wr_cmd && (wdata[7:4] != 4'hD) |=> !cmd_start); // R7

   AST_FORCE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd && (wdata[7:4] == 4'hD) |=> !busy_q); // R8

   AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && seq_done && !wr_cmd |=> intrq && !busy_q); // R6

   AST_MISSED_READ_LOST: assert property (@(posedge clk) disable iff (!rst_n)
      seq_rd_dir && dsk_in_vld && drq && !rd_dr && !wr_cmd |=> lost_flag); // R3

   AST_UNDERRUN_LOST: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_rd_dir && dsk_req && drq && !wr_cmd |=> lost_flag); // R5

   AST_HOST_FILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_rd_dir && wr_dr && !wr_cmd |=> !drq); // R4

   AST_IMM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      imm_held && !(wr_cmd && wdata == 8'hD0) |=> intrq); // R10

endmodule

bind fdc_host_regs fdc_host_regs_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_cmd     (wr_cmd),
   .wdata      (wdata),
   .busy_q     (busy_q),
   .seq_done   (seq_done),
   .intrq      (intrq),
   .cmd_start  (cmd_start),
   .seq_rd_dir (seq_rd_dir),
   .dsk_in_vld (dsk_in_vld),
   .dsk_req    (dsk_req),
   .drq        (drq),
   .lost_flag  (lost_flag),
   .rd_dr      (rd_dr),
   .wr_dr      (wr_dr),
   .imm_held   (imm_held)
);

// File: tb/sim_fdc_host_regs.sv
`timescale 1ns/1ps
module sim_fdc_host_regs;

   localparam int S = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic       drv_ready = 1'b0, drv_index = 1'b0, seq_trk0 = 1'b0;
   logic       seq_rd_dir = 1'b1, seq_done = 1'b0;
   logic       dsk_in_vld = 1'b0, dsk_req = 1'b0;
   logic [7:0] dsk_in_byte = 8'h00;

   logic [7:0] rdata, cmd_code, track_out, sector_out, dsk_out_byte;
   logic       drq, intrq, cmd_start, cmd_abort;

   always #10 clk = ~clk;

   fdc_host_regs #(.SYNC_STAGES(S)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .drq(drq), .intrq(intrq),
      .drv_ready(drv_ready), .drv_index(drv_index), .seq_trk0(seq_trk0),
      .seq_rd_dir(seq_rd_dir), .seq_done(seq_done), .cmd_start(cmd_start),
      .cmd_code(cmd_code), .cmd_abort(cmd_abort), .track_out(track_out),
      .sector_out(sector_out), .dsk_in_vld(dsk_in_vld), .dsk_in_byte(dsk_in_byte),
      .dsk_req(dsk_req), .dsk_out_byte(dsk_out_byte)
   );

   // ---------------- reference model ----------------
   int   vectors = 0, miscompares = 0;
   string cur_req = "R12";
   bit   finished = 0;

   int   hr[S+1];
   int   hx[S+1];
   bit   m_busy, m_type1, m_imm, m_irq, m_start, m_abort, m_drq, m_lost;
   bit   [2:0] m_cond;
   logic [7:0] m_trk, m_sec, m_dr, m_cmd;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_type1 = 1; m_imm = 0; m_irq = 0; m_start = 0; m_abort = 0;
         m_drq = 0; m_lost = 0; m_cond = 0;
         m_trk = 0; m_sec = 0; m_dr = 0; m_cmd = 0;
         for (int k = 0; k <= S; k++) begin hr[k] = 0; hx[k] = 0; end
      end else begin
         bit hrd, hwr, wcmd, frc, acc, rdst, rddr, wrdr, done, setq, clr;
         bit rr, rf, ir;
         bit n_drq, n_lost;
         logic [7:0] n_dr;
         hrd  = !cs_n && !rd_n;
         hwr  = !cs_n && !wr_n;
         wcmd = hwr && addr == 2'd0;
         frc  = wcmd && wdata[7:4] == 4'hD;
         acc  = wcmd && !frc && !m_busy;
         rdst = hrd && addr == 2'd0;
         rddr = hrd && addr == 2'd3;
         wrdr = hwr && addr == 2'd3;
         rr = hr[S-1] == 1 && hr[S] == 0;
         rf = hr[S-1] == 0 && hr[S] == 1;
         ir = hx[S-1] == 1 && hx[S] == 0;
         done = seq_done && m_busy && !frc;
         setq = done || (frc && wdata[3]) || (m_cond[0] && rr) || (m_cond[1] && rf) || (m_cond[2] && ir);
         clr = acc || (frc && !m_busy);

         // data register flow
         n_dr = m_dr; n_drq = m_drq; n_lost = m_lost;
         if (seq_rd_dir) begin
            if (dsk_in_vld) begin
               n_dr = dsk_in_byte;
               if (m_drq && !rddr) n_lost = 1;
               n_drq = 1;
            end else begin
               if (wrdr) n_dr = wdata;
               if (rddr || wrdr) n_drq = 0;
            end
         end else begin
            if (dsk_req && m_drq) n_lost = 1;
            if (wrdr) begin n_dr = wdata; n_drq = 0; end
            else if (dsk_req) n_drq = 1;
            else if (rddr) n_drq = 0;
         end
         if (clr) begin n_drq = 0; n_lost = 0; end

         m_start = acc;
         m_abort = frc && m_busy;
         if (acc) m_cmd = wdata;
         if (frc && !m_busy) m_type1 = 1;
         else if (acc) m_type1 = !wdata[7];
         if (setq) m_irq = 1;
         else if (rdst || acc || frc) m_irq = 0;
         if (frc) begin
            if (wdata[3]) m_imm = 1;
            else if (wdata[3:0] == 0) m_imm = 0;
            m_cond = wdata[2:0];
         end else if (acc) m_cond = 0;
         if (frc) m_busy = 0;
         else if (acc) m_busy = 1;
         else if (done) m_busy = 0;
         if (hwr && addr == 2'd1) m_trk = wdata;
         if (hwr && addr == 2'd2) m_sec = wdata;
         m_dr = n_dr; m_drq = n_drq; m_lost = n_lost;

         for (int k = S; k > 0; k--) begin hr[k] = hr[k-1]; hx[k] = hx[k-1]; end
         hr[0] = int'(drv_ready);
         hx[0] = int'(drv_index);
      end
   end

   function automatic logic [7:0] exp_rdata();
      logic [7:0] st;
      st = 8'h00;
      st[7] = (hr[S-1] == 0);
      st[0] = m_busy;
      if (m_type1) begin st[2] = seq_trk0; st[1] = (hx[S-1] == 1); end
      else begin st[2] = m_lost; st[1] = m_drq; end
      case (addr)
         2'd0: return st;
         2'd1: return m_trk;
         2'd2: return m_sec;
         default: return m_dr;
      endcase
   endfunction

   task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #5;
      if (rst_n && !finished) begin
         chk("rdata", rdata, exp_rdata());
         chk("drq", {7'd0, drq}, {7'd0, m_drq});
         chk("intrq", {7'd0, intrq}, {7'd0, m_irq | m_imm});
         chk("cmd_start", {7'd0, cmd_start}, {7'd0, m_start});
         chk("cmd_abort", {7'd0, cmd_abort}, {7'd0, m_abort});
         chk("cmd_code", cmd_code, m_cmd);
         chk("track_out", track_out, m_trk);
         chk("sector_out", sector_out, m_sec);
         chk("dsk_out_byte", dsk_out_byte, m_drq ? 8'h00 : m_dr);
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); cs_n = 0; wr_n = 0; addr = a; wdata = d;
      @(negedge clk); cs_n = 1; wr_n = 1;
   endtask

   task automatic rd(input logic [1:0] a);
      @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
      @(negedge clk); cs_n = 1; rd_n = 1;
   endtask

   task automatic peek(input logic [1:0] a);
      @(negedge clk); addr = a;
   endtask

   task automatic disk_byte(input logic [7:0] b);
      @(negedge clk); dsk_in_vld = 1; dsk_in_byte = b;
      @(negedge clk); dsk_in_vld = 0;
   endtask

   task automatic disk_need();
      @(negedge clk); dsk_req = 1;
      @(negedge clk); dsk_req = 0;
   endtask

   task automatic finish_cmd();
      @(negedge clk); seq_done = 1;
      @(negedge clk); seq_done = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         miscompares++;
         $display("FAIL watchdog expired, run did not complete");
         summary();
         $finish;
      end
   end

   // ---------------- script ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      cur_req = "R12"; peek(2'd0); idle(2);     // reset: positioning form, not ready

      cur_req = "R1";
      wr(2'd1, 8'h22); wr(2'd2, 8'h05); wr(2'd3, 8'h5A);
      rd(2'd1); rd(2'd2); rd(2'd3);

      cur_req = "R12";
      drv_ready = 1; seq_trk0 = 1; idle(4); peek(2'd0); idle(1);
      drv_index = 1; idle(4); drv_index = 0; idle(4);

      cur_req = "R7";
      wr(2'd0, 8'h88); idle(1);                 // read sector, transfer form
      wr(2'd0, 8'h18); idle(1); peek(2'd0);     // ignored while busy

      cur_req = "R2";
      seq_rd_dir = 1;
      disk_byte(8'h11); peek(2'd3); rd(2'd3); idle(1);
      cur_req = "R3";
      disk_byte(8'h22); idle(1); disk_byte(8'h33); peek(2'd0); idle(1); rd(2'd3);
      peek(2'd0); idle(1);

      cur_req = "R6";
      finish_cmd(); idle(2); rd(2'd0); idle(1);

      cur_req = "R4";
      wr(2'd0, 8'hA8); seq_rd_dir = 0; idle(1);
      wr(2'd3, 8'h44); disk_need(); wr(2'd3, 8'h55); disk_need();
      cur_req = "R5";
      disk_need(); idle(1); peek(2'd0); idle(1);
      cur_req = "R4";
      wr(2'd3, 8'h66); idle(1);

      cur_req = "R8";
      wr(2'd0, 8'hD0); idle(3);                 // ends running command, no irq
      cur_req = "R11";
      peek(2'd0); idle(1);
      wr(2'd0, 8'hD0); idle(1); peek(2'd0); idle(2);

      cur_req = "R9";
      wr(2'd0, 8'hD2); idle(1);
      drv_ready = 0; idle(6); rd(2'd0); idle(1);
      wr(2'd0, 8'hD1); drv_ready = 1; idle(6); rd(2'd0);
      wr(2'd0, 8'hD4); drv_index = 1; idle(5); drv_index = 0; idle(3); rd(2'd0);
      wr(2'd0, 8'hD3); drv_ready = 0; idle(6); rd(2'd0);
      wr(2'd0, 8'h01); drv_ready = 1; idle(6);  // accepted command disarms
      finish_cmd(); rd(2'd0); idle(2);

      cur_req = "R10";
      wr(2'd0, 8'hD8); idle(2); rd(2'd0); idle(2);
      wr(2'd0, 8'h00); idle(2); finish_cmd(); rd(2'd0);
      wr(2'd0, 8'hD4); idle(2);
      wr(2'd0, 8'hD0); idle(3);

      cur_req = "R6";
      wr(2'd0, 8'h0C); finish_cmd(); idle(1); wr(2'd0, 8'h84); idle(2);
      wr(2'd0, 8'hD0); idle(2);

      cur_req = "R2";
      seq_rd_dir = 1; wr(2'd0, 8'h80);
      disk_byte(8'hA1);
      @(negedge clk); dsk_in_vld = 1; dsk_in_byte = 8'hB2; cs_n = 0; rd_n = 0; addr = 2'd3;
      @(negedge clk); dsk_in_vld = 0; cs_n = 1; rd_n = 1;
      peek(2'd0); idle(2);
      wr(2'd0, 8'hD0); idle(2);

      finished = 1;
      summary();
      $finish;
   end

endmodule